// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filter

This block recovers asynchronous serial characters from a single receive line. A one-cycle enable, `os_tick`, is pulsed sixteen times per bit period. On each tick the block samples the line, after a two-flop synchronizer. It confirms the start bit, votes each bit from three centre samples, and assembles an 8-bit or 9-bit character. With 8 data bits an optional parity bit follows. The character closes with one or two stop bits.

Each finished character is written into a four-entry first-in first-out queue, together with a parity-error tag and a framing-error tag. The host reads the oldest entry from the head of the queue and removes it with `pop`. Several behaviours are built around the queue:
- A 9-bit address filter discards data characters, so a node on a shared line only sees address characters.
- A sticky overrun flag records characters that were lost because the queue was full.
- A flow-control output tells the far end when to stop sending.
- Two interrupt outputs are provided: one for data waiting and one for any error.

A loopback selector lets the block listen to a local transmitter instead of the pin.

Top module: `rx_frame_unit`

## Requirements
- R1: Accepted characters are stored in a queue of 4 entries and leave it in arrival order. `head_word`, `head_perr` and `head_ferr` show the oldest entry. A `pop` pulse removes that entry.
- R2: A falling edge starts a character only if the line is still low at the 8th tick after the edge. Otherwise the receiver returns to idle and stores nothing.
- R3: Each data, parity and stop bit takes the majority of the samples at ticks 7, 8 and 9 of its bit period. A single-tick glitch at the bit centre does not change the received value.
- R4: The frame format is selected by three inputs. Data bits go LSB first.
  - `nine_bit`=1 gives 9 data bits, `head_word[8]` holds the ninth bit, and there is no parity.
  - Otherwise there are 8 data bits and `head_word[8]` reads 0. `par_mode` selects parity: 0 none, 1 even, 2 odd.
  - `two_stop` selects one or two stop bits.
- R5: `head_perr` is 1 when the received parity bit differs from the value that gives an even (mode 1) or odd (mode 2) count of ones over data plus parity.
- R6: `head_ferr` is 1 when the first stop bit is voted low.
- R7: A character that completes while the queue is full is discarded and sets `overrun`. `overrun` stays 1 until a `ovr_clr` pulse, and the queued entries are unchanged.
- R8: With `nine_bit`=1 and `addr_only`=1, a character whose ninth bit is 0 is not stored. A character whose ninth bit is 1 is stored.
- R9: `rts` is 0 while the queue holds 4 entries and 1 whenever at least one entry is free.
- R10: `rx_irq` is 1 while the queue is not empty. `err_irq` is 1 while `overrun` is set or the head entry carries a parity or framing tag.
- R11: With `loop_en`=1 the receiver listens to `loop_src` and ignores `rx_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle enable, 16 per bit period |
| rx_pin | input | 1 | Serial receive line, idle high |
| loop_src | input | 1 | Local transmit line used in loopback |
| loop_en | input | 1 | 1 selects `loop_src` as the receive source |
| nine_bit | input | 1 | 1 selects 9 data bits |
| par_mode | input | 2 | 0 none, 1 even, 2 odd (8-bit only) |
| two_stop | input | 1 | 1 selects two stop bits |
| addr_only | input | 1 | Address filter enable (9-bit only) |
| pop | input | 1 | Removes the head entry |
| ovr_clr | input | 1 | Clears the overrun flag |
| head_word | output | 9 | Oldest stored character |
| head_perr | output | 1 | Parity tag of the head entry |
| head_ferr | output | 1 | Framing tag of the head entry |
| overrun | output | 1 | Sticky overrun flag |
| rts | output | 1 | 1 = room to receive |
| rx_irq | output | 1 | Data waiting |
| err_irq | output | 1 | Any error condition |

## Verification
A table of characters is sent in several formats: 8 bits with no parity, even parity and odd parity; two stop bits; and 9 bits with and without the address filter. These cases tell apart bit ordering, ninth-bit placement, the parity polarity and the filter decision. The table also carries a corrupted parity bit and a low stop bit, to show that each tag is set on its own and never both. A mid-bit glitch shows that the majority vote is used rather than a single sample. Directed runs cover:
- a short start pulse that must be rejected;
- filling the queue, then overrunning it, checking `rts`, order preservation and the sticky flag;
- loopback while the pin is held low.

// File: rtl/rxu_pkg.sv
// Shared types for the serial receiver.
// Assumes: characters are at most 9 bits wide.
package rxu_pkg;
    localparam int WORD_W = 9;

    localparam logic [1:0] PAR_NONE = 2'd0;
    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              perr;
        logic              ferr;
    } rx_entry_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_BITS,
        PH_STOP
    } rx_phase_t;
endpackage

// File: rtl/rxu_bit_engine.sv
// Bit engine: detects the start bit, votes each bit from three centre
// samples and assembles one character per frame. It pulses char_done
// for one cycle with the word and its error tags.
// Assumes: rx is already synchronised, and os_tick is a single-cycle
// enable arriving OVS times per bit.
module rxu_bit_engine
    import rxu_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx,
    input  logic              nine_bit,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    output logic              char_done,
    output logic [WORD_W-1:0] char_word,
    output logic              char_perr,
    output logic              char_ferr
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] S_MID  = CW'(OVS / 2);
    localparam logic [CW-1:0] S_PRE  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] S_POST = CW'(OVS / 2 + 1);
    localparam logic [CW-1:0] S_LAST = CW'(OVS - 1);

    rx_phase_t         phase;
    logic [CW-1:0]     tcnt;
    logic [3:0]        bidx;
    logic              sidx;
    logic [1:0]        vote;
    logic [WORD_W-1:0] sreg;
    logic              ferr_q;
    logic              maj;
    logic              par_on;
    logic [3:0]        nbits;
    logic              exp_par;

    // Majority of the two stored samples and the current one.
    assign maj     = (vote[0] & vote[1]) | (vote[0] & rx) | (vote[1] & rx);
    assign par_on  = !nine_bit && (par_mode != PAR_NONE);
    assign nbits   = (nine_bit ? 4'd9 : 4'd8) + (par_on ? 4'd1 : 4'd0);
    assign exp_par = (^sreg[7:0]) ^ (par_mode == PAR_ODD);

    // Frame sequencer: walks start, data/parity and stop bits, one tick at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            sidx      <= 1'b0;
            vote      <= '0;
            sreg      <= '0;
            ferr_q    <= 1'b0;
            char_done <= 1'b0;
        end else begin
            char_done <= 1'b0;
            if (os_tick) begin
                tcnt <= tcnt + 1'b1;
                unique case (phase)
                    PH_IDLE: begin
                        if (!rx) begin
                            phase  <= PH_START;
                            tcnt   <= CW'(1);
                            ferr_q <= 1'b0;
                            sreg   <= '0;
                        end
                    end
                    PH_START: begin
                        if (tcnt == S_MID && rx) begin
                            phase <= PH_IDLE;
                        end else if (tcnt == S_LAST) begin
                            phase <= PH_BITS;
                            bidx  <= '0;
                        end
                    end
                    PH_BITS: begin
                        if (tcnt == S_PRE)  vote[0] <= rx;
                        if (tcnt == S_MID)  vote[1] <= rx;
                        if (tcnt == S_POST) sreg[bidx] <= maj;
                        if (tcnt == S_LAST) begin
                            if (bidx == nbits - 4'd1) begin
                                phase <= PH_STOP;
                                sidx  <= 1'b0;
                            end else begin
                                bidx <= bidx + 4'd1;
                            end
                        end
                    end
                    PH_STOP: begin
                        if (tcnt == S_PRE)  vote[0] <= rx;
                        if (tcnt == S_MID)  vote[1] <= rx;
                        if (tcnt == S_POST && !sidx) ferr_q <= !maj;
                        if (tcnt == S_LAST) begin
                            if (sidx == two_stop) begin
                                phase     <= PH_IDLE;
                                char_done <= 1'b1;
                            end else begin
                                sidx <= 1'b1;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // Word and tags presented alongside char_done.
    always_comb begin
        char_word = nine_bit ? sreg : {1'b0, sreg[7:0]};
        char_perr = par_on && (sreg[8] != exp_par);
        char_ferr = ferr_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> !char_done);                                     // R4
    AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START && os_tick && tcnt == S_MID && rx) |=> phase == PH_IDLE); // R2
endmodule

// File: rtl/rxu_queue.sv
// Receive queue: first-in first-out store of received entries.
// A push is refused when the queue is full; a pop is ignored when it is empty.
// Assumes: the caller decides what happens to a refused push.
module rxu_queue
    import rxu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int AW = $clog2(DEPTH);

    rx_entry_t   mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            count <= count + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1)
        || (count == $past(count) - 1'b1));                            // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);                              // R7
endmodule

// File: rtl/rx_frame_unit.sv
// Top of the serial receiver. Selects the line source and synchronises it,
// recovers characters, filters 9-bit data characters in address mode,
// queues the results, keeps the sticky overrun flag, and drives flow
// control and the two interrupts.
// Assumes: os_tick comes from an external baud divider at 16x the bit rate.
module rx_frame_unit
    import rxu_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_pin,
    input  logic              loop_src,
    input  logic              loop_en,
    input  logic              nine_bit,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic              addr_only,
    input  logic              pop,
    input  logic              ovr_clr,
    output logic [WORD_W-1:0] head_word,
    output logic              head_perr,
    output logic              head_ferr,
    output logic              overrun,
    output logic              rts,
    output logic              rx_irq,
    output logic              err_irq
);
    logic [1:0]        sync_q;
    logic              done;
    logic [WORD_W-1:0] word;
    logic              perr, ferr;
    logic              keep, push;
    logic              q_empty, q_full;
    rx_entry_t         q_in, q_head;

    // Two-flop synchroniser on the selected source, reset to idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], loop_en ? loop_src : rx_pin};
    end

    rxu_bit_engine #(.OVS(OVS)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx        (sync_q[1]),
        .nine_bit  (nine_bit),
        .par_mode  (par_mode),
        .two_stop  (two_stop),
        .char_done (done),
        .char_word (word),
        .char_perr (perr),
        .char_ferr (ferr)
    );

    // Address filter: in address mode only ninth-bit-set characters pass.
    assign keep = !(nine_bit && addr_only && !word[8]);
    assign push = done && keep;
    assign q_in = '{word: word, perr: perr, ferr: ferr};

    rxu_queue #(.DEPTH(DEPTH)) i_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (q_in),
        .pop   (pop),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    // Sticky overrun: set by a push into a full queue, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= (overrun && !ovr_clr) || (push && q_full);
    end

    // Host-facing outputs.
    always_comb begin
        head_word = q_head.word;
        head_perr = q_head.perr;
        head_ferr = q_head.ferr;
        rts       = !q_full;
        rx_irq    = !q_empty;
        err_irq   = overrun || (!q_empty && (q_head.perr || q_head.ferr));
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);                            // R7
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(q_full));                             // R7
endmodule

// File: tb/test_rx_frame_unit.sv
module test_rx_frame_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_pin = 1'b1, loop_src = 1'b1, loop_en = 1'b0;
    logic nine_bit = 1'b0, two_stop = 1'b0, addr_only = 1'b0;
    logic [1:0] par_mode = 2'd0;
    logic pop = 1'b0, ovr_clr = 1'b0;
    logic [8:0] head_word;
    logic head_perr, head_ferr, overrun, rts, rx_irq, err_irq;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    rx_frame_unit i_rx_frame_unit (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
        .loop_src(loop_src), .loop_en(loop_en), .nine_bit(nine_bit),
        .par_mode(par_mode), .two_stop(two_stop), .addr_only(addr_only),
        .pop(pop), .ovr_clr(ovr_clr), .head_word(head_word),
        .head_perr(head_perr), .head_ferr(head_ferr), .overrun(overrun),
        .rts(rts), .rx_irq(rx_irq), .err_irq(err_irq));

    typedef struct packed {
        logic       nine;
        logic [1:0] par;
        logic       two;
        logic       addr;
        logic [8:0] w;
        logic       bad_par;
        logic       bad_stop;
        logic       glitch;
        logic       stored;
        logic       perr;
        logic       ferr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'd1, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'd2, 1'b1, 1'b0, 9'h007, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'd1, 1'b0, 1'b0, 9'h05A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 9'h0FF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 2'd0, 1'b0, 1'b1, 9'h1AB, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b1, 9'h0AB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 9'h055, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 9'h096, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input logic ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_line(input logic via_loop, input logic v);
        if (via_loop) loop_src = v;
        else          rx_pin = v;
    endtask

    // One bit lasts 16 ticks = 32 clocks; an optional 2-clock flip at bit 1 centre.
    task automatic send(input logic [8:0] w, input logic nine, input logic [1:0] par,
                        input logic two, input logic bad_par, input logic bad_stop,
                        input logic glitch, input logic via_loop);
        logic [12:0] bits;
        int n;
        logic p;
        n = 0;
        bits = '0;
        bits[n++] = 1'b0;
        for (int i = 0; i < (nine ? 9 : 8); i++) bits[n++] = w[i];
        if (!nine && par != 2'd0) begin
            p = (^w[7:0]) ^ (par == 2'd2) ^ bad_par;
            bits[n++] = p;
        end
        bits[n++] = !bad_stop;
        if (two) bits[n++] = 1'b1;
        for (int b = 0; b < n; b++) begin
            for (int c = 0; c < 32; c++) begin
                @(negedge clk);
                put_line(via_loop, (glitch && b == 1 && (c == 16 || c == 17)) ? ~bits[b] : bits[b]);
            end
        end
        @(negedge clk);
        put_line(via_loop, 1'b1);
        repeat (40) @(negedge clk);
    endtask

    task automatic do_pop;
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(rx_irq == 1'b0, "R10 reset rx_irq", {8'b0, rx_irq}, 9'h0);
        chk(err_irq == 1'b0, "R10 reset err_irq", {8'b0, err_irq}, 9'h0);
        chk(rts == 1'b1, "R9 reset rts", {8'b0, rts}, 9'h1);
        chk(overrun == 1'b0, "R7 reset overrun", {8'b0, overrun}, 9'h0);

        // Table walk: formats R4, parity R5, framing R6, address R8, vote R3
        for (int v = 0; v < NV; v++) begin
            nine_bit = VECS[v].nine; par_mode = VECS[v].par;
            two_stop = VECS[v].two;  addr_only = VECS[v].addr;
            send(VECS[v].w, VECS[v].nine, VECS[v].par, VECS[v].two,
                 VECS[v].bad_par, VECS[v].bad_stop, VECS[v].glitch, 1'b0);
            if (VECS[v].stored) begin
                chk(rx_irq == 1'b1, "R10 rx_irq on data", {8'b0, rx_irq}, 9'h1);
                chk(head_word == (VECS[v].nine ? VECS[v].w : {1'b0, VECS[v].w[7:0]}),
                    "R4/R3/R8 word", head_word, VECS[v].w);
                chk(head_perr == VECS[v].perr, "R5 parity tag", {8'b0, head_perr}, {8'b0, VECS[v].perr});
                chk(head_ferr == VECS[v].ferr, "R6 framing tag", {8'b0, head_ferr}, {8'b0, VECS[v].ferr});
                chk(err_irq == (VECS[v].perr | VECS[v].ferr), "R10 err_irq",
                    {8'b0, err_irq}, {8'b0, VECS[v].perr | VECS[v].ferr});
                do_pop();
            end
            chk(rx_irq == 1'b0, "R8 R1 queue empty after vector", {8'b0, rx_irq}, 9'h0);
        end

        // R2: short start pulse of 3 ticks
        nine_bit = 1'b0; par_mode = 2'd0; two_stop = 1'b0; addr_only = 1'b0;
        repeat (6) @(negedge clk) rx_pin = 1'b0;
        @(negedge clk) rx_pin = 1'b1;
        repeat (400) @(negedge clk);
        chk(rx_irq == 1'b0, "R2 short start ignored", {8'b0, rx_irq}, 9'h0);

        // R9 / R7 / R1: fill, overrun, drain
        for (int k = 1; k <= 4; k++) begin
            send(9'(k * 17), 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            if (k == 3) chk(rts == 1'b1, "R9 rts with free entry", {8'b0, rts}, 9'h1);
        end
        chk(rts == 1'b0, "R9 rts low when full", {8'b0, rts}, 9'h0);
        chk(overrun == 1'b0, "R7 no overrun yet", {8'b0, overrun}, 9'h0);
        send(9'h055, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(overrun == 1'b1, "R7 overrun set", {8'b0, overrun}, 9'h1);
        chk(err_irq == 1'b1, "R10 err_irq on overrun", {8'b0, err_irq}, 9'h1);
        for (int k = 1; k <= 4; k++) begin
            chk(head_word == 9'(k * 17), "R1 R7 order kept", head_word, 9'(k * 17));
            do_pop();
            chk(rts == 1'b1, "R9 rts after pop", {8'b0, rts}, 9'h1);
        end
        chk(rx_irq == 1'b0, "R7 overrun word discarded", {8'b0, rx_irq}, 9'h0);
        chk(overrun == 1'b1, "R7 overrun sticky", {8'b0, overrun}, 9'h1);
        @(negedge clk) ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
        chk(overrun == 1'b0, "R7 overrun cleared", {8'b0, overrun}, 9'h0);
        chk(err_irq == 1'b0, "R10 err_irq cleared", {8'b0, err_irq}, 9'h0);

        // R11: loopback with the pin held low
        loop_en = 1'b1;
        rx_pin = 1'b0;
        repeat (10) @(negedge clk);
        send(9'h06E, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(head_word == 9'h06E, "R11 loopback word", head_word, 9'h06E);
        do_pop();
        chk(rx_irq == 1'b0, "R11 pin ignored", {8'b0, rx_irq}, 9'h0);

        finish_run();
    end
endmodule